// File: doc/BRIEF.md
# Wide 64-byte Store Request Builder

This block converts one already-decoded 64-byte atomic store into a single write request for the memory system. When it is idle it accepts a command that holds the index of the first data register, the index of the base register, a feature-enable bit, the endianness mode and the current stack pointer. It then walks a single 64-bit register-file read port, one register per cycle. First it fetches the eight consecutive data registers and then, if needed, the base register. It packs the data registers into a 512-bit payload.

Before any read, the block checks whether the command is allowed and whether the stack pointer is aligned. After the address is known, it checks 64-byte alignment. A command that fails any check produces a one-cycle fault report with a code and no request. A command that passes produces one request with the payload, the address and a tag-check flag. The request stays on a valid/ready output until the consumer takes it.

Top module: `blk64_store_builder`

## Requirements
- R1: When `feat_en` is low at acceptance, the block reports fault code 1 (undefined) in the cycle after the accepting edge. It makes no register-file read and issues no request.
- R2: A first-register index whose two top bits are both 1, or whose bit 0 is 1, is reported as fault code 1 (undefined) with no read and no request. This fault takes priority over every other fault.
- R3: A legal command reads registers rt, rt+1, …, rt+7 in ascending order, one per cycle, starting in the cycle after acceptance. If the base index is not 31, one more read of register rn follows. `rf_data` is expected in the same cycle as `rf_addr`.
- R4: In little-endian mode (`big_endian` low), payload bits [64*i+63:64*i] hold register rt+i, so register rt is the lowest doubleword.
- R5: In big-endian mode, each doubleword is byte-reversed on its own. The position of each doubleword in the payload does not change.
- R6: A base index of 31 takes the address from the stack pointer sampled at acceptance and reads no base register. Any other index takes the value of register rn unchanged, with no offset added.
- R7: `req_tagchk` is high exactly when the base index is not 31.
- R8: A base index of 31 with stack-pointer bits [3:0] not all zero gives fault code 2 (stack alignment) in the cycle after acceptance, with no read. Code 1 has priority over it.
- R9: An address whose bits [5:0] are not all zero gives fault code 3 (64-byte alignment) and no request. The fault appears 8 cycles after acceptance when the base index is 31, and 9 cycles after otherwise.
- R10: A request first shows 8 cycles after the accepting edge when the base index is 31, and 9 cycles after otherwise. It holds `req_valid`, address, data and flag unchanged until an edge where `req_ready` is high, and then drops.
- R11: `cmd_ready` is high only when the block is idle. After a fault cycle, or after a request is taken, the block is idle again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command taken on this edge |
| cmd_rt | input | 5 | First data register index |
| cmd_rn | input | 5 | Base register index (31 = stack pointer) |
| feat_en | input | 1 | Feature enable |
| big_endian | input | 1 | Byte-reverse each doubleword |
| sp_value | input | 64 | Current stack pointer |
| rf_rd_en | output | 1 | Register-file read strobe |
| rf_addr | output | 5 | Register-file read index |
| rf_data | input | 64 | Register-file read data, same cycle |
| req_valid | output | 1 | Store request valid |
| req_ready | input | 1 | Store request accepted |
| req_addr | output | 64 | Store address |
| req_data | output | 512 | Store payload |
| req_tagchk | output | 1 | Tag check required |
| fault_valid | output | 1 | One-cycle fault report |
| fault_code | output | 2 | 1 undefined, 2 stack alignment, 3 64-byte alignment |

## Verification
Every result is due a fixed number of edges after the accepting edge:
- Undefined and stack-alignment faults are due after one edge.
- Requests and 64-byte alignment faults are due after eight edges when the base index is 31, and after nine edges otherwise.

The bench drives inputs and samples outputs on the falling edge. It counts falling edges from the accepting edge, requires the first response at exactly the expected count, and logs every read strobe on the way to check the order and the count of reads. For a request, it holds `req_ready` low for a few cycles and checks that the request stays stable. It then checks that `cmd_ready` comes back one cycle after the response is consumed.

// File: rtl/blk64_pkg.sv
package blk64_pkg;

    localparam int XLEN       = 64;
    localparam int LANES      = 8;
    localparam int RIDX_W     = 5;
    localparam int SP_AL_BITS = 4;
    localparam int ST_AL_BITS = 6;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_UNDEF   = 2'd1,
        FLT_SPALIGN = 2'd2,
        FLT_ALIGN   = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_FAULT,
        ST_SEND
    } state_e;

    typedef struct packed {
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rn;
        logic              be;
    } cmd_s;

    function automatic logic [XLEN-1:0] swap_bytes(input logic [XLEN-1:0] v);
        logic [XLEN-1:0] r;
        for (int b = 0; b < XLEN / 8; b++) begin
            r[8*b +: 8] = v[XLEN - 8*(b+1) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/blk64_legal_chk.sv
module blk64_legal_chk
    import blk64_pkg::*;
#(
    parameter int IDX_W   = RIDX_W,
    parameter int DW      = XLEN,
    parameter int SP_BITS = SP_AL_BITS
) (
    input  logic             feat_en,
    input  logic [IDX_W-1:0] rt,
    input  logic [IDX_W-1:0] rn,
    input  logic [DW-1:0]    sp,
    output fault_e           pre_fault
);
    logic rt_bad;
    logic sp_bad;

    always_comb begin
        rt_bad = (rt[IDX_W-1:IDX_W-2] == 2'b11) || rt[0];
        sp_bad = (rn == {IDX_W{1'b1}}) && (sp[SP_BITS-1:0] != '0);
        if (!feat_en || rt_bad) begin
            pre_fault = FLT_UNDEF;
        end else if (sp_bad) begin
            pre_fault = FLT_SPALIGN;
        end else begin
            pre_fault = FLT_NONE;
        end
    end
endmodule

// File: rtl/blk64_seq.sv
module blk64_seq
    import blk64_pkg::*;
#(
    parameter int NLANE = LANES,
    localparam int CW   = $clog2(NLANE + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_fire,
    input  fault_e        pre_fault,
    input  logic          rn_is_sp,
    input  logic          addr_aligned,
    input  logic          req_ready,
    output logic          idle,
    output logic          rd_en,
    output logic [CW-1:0] idx,
    output logic          at_base,
    output logic          lane_wr,
    output logic          base_wr,
    output logic          req_valid,
    output logic          fault_valid,
    output fault_e        fault_code
);
    localparam logic [CW-1:0] LAST_LANE = CW'(NLANE - 1);
    localparam logic [CW-1:0] BASE_SLOT = CW'(NLANE);

    state_e        state_q;
    logic [CW-1:0] idx_q;
    fault_e        fcode_q;
    logic          decide;

    always_comb begin
        idle        = (state_q == ST_IDLE);
        rd_en       = (state_q == ST_READ);
        at_base     = (idx_q == BASE_SLOT);
        lane_wr     = rd_en && !at_base;
        base_wr     = rd_en && at_base;
        decide      = rd_en && (at_base || ((idx_q == LAST_LANE) && rn_is_sp));
        req_valid   = (state_q == ST_SEND);
        fault_valid = (state_q == ST_FAULT);
        fault_code  = fault_valid ? fcode_q : FLT_NONE;
        idx         = idx_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            fcode_q <= FLT_NONE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cmd_fire) begin
                        idx_q <= '0;
                        if (pre_fault != FLT_NONE) begin
                            fcode_q <= pre_fault;
                            state_q <= ST_FAULT;
                        end else begin
                            state_q <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (decide) begin
                        if (addr_aligned) begin
                            state_q <= ST_SEND;
                        end else begin
                            fcode_q <= FLT_ALIGN;
                            state_q <= ST_FAULT;
                        end
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_FAULT: state_q <= ST_IDLE;
                ST_SEND: begin
                    if (req_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/blk64_pack.sv
module blk64_pack
    import blk64_pkg::*;
#(
    parameter int DW    = XLEN,
    parameter int NLANE = LANES,
    localparam int LW   = $clog2(NLANE)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [LW-1:0]       wr_lane,
    input  logic                be,
    input  logic [DW-1:0]       din,
    output logic [DW*NLANE-1:0] payload
);
    logic [DW-1:0] lane_in;

    always_comb lane_in = be ? swap_bytes(din) : din;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [DW-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q <= '0;
            end else if (wr_en && (wr_lane == LW'(g))) begin
                lane_q <= lane_in;
            end
        end
        assign payload[DW*g +: DW] = lane_q;
    end
endmodule

// File: rtl/blk64_store_builder.sv
module blk64_store_builder
    import blk64_pkg::*;
#(
    parameter int DW    = XLEN,
    parameter int NLANE = LANES,
    parameter int IDX_W = RIDX_W,
    parameter int ALIGN = ST_AL_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [IDX_W-1:0]    cmd_rt,
    input  logic [IDX_W-1:0]    cmd_rn,
    input  logic                feat_en,
    input  logic                big_endian,
    input  logic [DW-1:0]       sp_value,
    output logic                rf_rd_en,
    output logic [IDX_W-1:0]    rf_addr,
    input  logic [DW-1:0]       rf_data,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [DW-1:0]       req_addr,
    output logic [DW*NLANE-1:0] req_data,
    output logic                req_tagchk,
    output logic                fault_valid,
    output logic [1:0]          fault_code
);
    localparam int CW = $clog2(NLANE + 1);
    localparam int LW = $clog2(NLANE);
    localparam logic [IDX_W-1:0] SP_IDX = {IDX_W{1'b1}};

    cmd_s          cmd_q;
    logic [DW-1:0] addr_q;
    logic          cmd_fire;
    fault_e        pre_fault;
    fault_e        fcode;
    logic          idle;
    logic [CW-1:0] idx;
    logic          at_base;
    logic          lane_wr;
    logic          base_wr;
    logic          rn_is_sp;
    logic [DW-1:0] addr_src;
    logic          addr_aligned;

    assign cmd_fire = cmd_valid && idle;
    assign cmd_ready = idle;

    blk64_legal_chk #(.IDX_W(IDX_W), .DW(DW), .SP_BITS(SP_AL_BITS)) u_legal (
        .feat_en   (feat_en),
        .rt        (cmd_rt),
        .rn        (cmd_rn),
        .sp        (sp_value),
        .pre_fault (pre_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            addr_q <= '0;
        end else begin
            if (cmd_fire) begin
                cmd_q.rt <= cmd_rt;
                cmd_q.rn <= cmd_rn;
                cmd_q.be <= big_endian;
                addr_q   <= sp_value;
            end else if (base_wr) begin
                addr_q <= rf_data;
            end
        end
    end

    always_comb begin
        rn_is_sp     = (cmd_q.rn == SP_IDX);
        addr_src     = at_base ? rf_data : addr_q;
        addr_aligned = (addr_src[ALIGN-1:0] == '0);
        rf_addr      = at_base ? cmd_q.rn : cmd_q.rt + IDX_W'(idx);
    end

    blk64_seq #(.NLANE(NLANE)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .cmd_fire     (cmd_fire),
        .pre_fault    (pre_fault),
        .rn_is_sp     (rn_is_sp),
        .addr_aligned (addr_aligned),
        .req_ready    (req_ready),
        .idle         (idle),
        .rd_en        (rf_rd_en),
        .idx          (idx),
        .at_base      (at_base),
        .lane_wr      (lane_wr),
        .base_wr      (base_wr),
        .req_valid    (req_valid),
        .fault_valid  (fault_valid),
        .fault_code   (fcode)
    );

    blk64_pack #(.DW(DW), .NLANE(NLANE)) u_pack (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (lane_wr),
        .wr_lane (idx[LW-1:0]),
        .be      (cmd_q.be),
        .din     (rf_data),
        .payload (req_data)
    );

    assign req_addr   = addr_q;
    assign req_tagchk = !rn_is_sp;
    assign fault_code = fcode;
endmodule

// File: rtl/blk64_store_chk.sv
module blk64_store_chk #(
    parameter int DW    = 64,
    parameter int NLANE = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                cmd_ready,
    input logic                rf_rd_en,
    input logic                req_valid,
    input logic                req_ready,
    input logic [DW-1:0]       req_addr,
    input logic [DW*NLANE-1:0] req_data,
    input logic                req_tagchk,
    input logic                fault_valid,
    input logic [1:0]          fault_code
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data) && $stable(req_tagchk)) // R10
        else $error("request changed while stalled");
    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_addr[5:0] == 6'd0) // R9
        else $error("misaligned request issued");
    AST_FAULT_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !(fault_valid && req_valid)) // R9
        else $error("fault and request together");
    AST_FAULT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        fault_valid |=> !fault_valid && cmd_ready) // R11
        else $error("fault not followed by idle");
    AST_FAULT_CODE: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> fault_code != 2'd0) // R1
        else $error("fault without code");
    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !rf_rd_en && !req_valid && !fault_valid) // R11
        else $error("activity while idle");
    AST_TAKE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> cmd_ready) // R10
        else $error("not idle after take");
endmodule

bind blk64_store_builder blk64_store_chk #(.DW(DW), .NLANE(NLANE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_ready   (cmd_ready),
    .rf_rd_en    (rf_rd_en),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_data    (req_data),
    .req_tagchk  (req_tagchk),
    .fault_valid (fault_valid),
    .fault_code  (fault_code)
);

// File: tb/blk64_store_builder_test.sv
module blk64_store_builder_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         cmd_valid;
    logic         cmd_ready;
    logic [4:0]   cmd_rt;
    logic [4:0]   cmd_rn;
    logic         feat_en;
    logic         big_endian;
    logic [63:0]  sp_value;
    logic         rf_rd_en;
    logic [4:0]   rf_addr;
    logic [63:0]  rf_data;
    logic         req_valid;
    logic         req_ready;
    logic [63:0]  req_addr;
    logic [511:0] req_data;
    logic         req_tagchk;
    logic         fault_valid;
    logic [1:0]   fault_code;

    logic [63:0]  regs [32];
    int           n_chk = 0;
    int           n_bad = 0;

    always #2 clk = ~clk;

    assign rf_data = regs[rf_addr];

    blk64_store_builder uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_rt(cmd_rt), .cmd_rn(cmd_rn), .feat_en(feat_en), .big_endian(big_endian),
        .sp_value(sp_value), .rf_rd_en(rf_rd_en), .rf_addr(rf_addr), .rf_data(rf_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_data(req_data), .req_tagchk(req_tagchk), .fault_valid(fault_valid),
        .fault_code(fault_code)
    );

    task automatic check(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] rev8(input logic [63:0] v);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[63-8*k -: 8] = v[8*k +: 8];
        return r;
    endfunction

    // exp_fault: 0 request, else code; exp_k: falling edges after accept
    task automatic run_case(input string name, input logic [4:0] rt, input logic [4:0] rn,
                            input logic fe, input logic be, input logic [63:0] sp,
                            input logic [1:0] exp_fault, input int exp_k, input int stall);
        int           k;
        int           nrd;
        logic [4:0]   rd_log [16];
        logic [511:0] exp_data;
        logic [63:0]  exp_addr;
        int           exp_nrd;
        @(negedge clk);
        check(cmd_ready, {name, " R11 idle before cmd"}, cmd_ready, 1);
        cmd_valid = 1'b1; cmd_rt = rt; cmd_rn = rn; feat_en = fe; big_endian = be; sp_value = sp;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        sp_value = 64'hDEAD_BEEF_0000_0007;
        k = 0; nrd = 0;
        while (!req_valid && !fault_valid && k < 20) begin
            if (cmd_ready) check(0, {name, " R11 busy not idle"}, cmd_ready, 0);
            if (rf_rd_en && nrd < 16) begin rd_log[nrd] = rf_addr; nrd++; end
            @(negedge clk);
            k++;
        end
        check(k == exp_k, {name, " R10 R9 response cycle"}, k, exp_k);
        if (exp_fault != 0) begin
            check(fault_valid && fault_code == exp_fault, {name, " R1 R2 R8 R9 fault code"},
                  {fault_valid, fault_code}, {1'b1, exp_fault});
            exp_nrd = (exp_fault == 2'd3) ? ((rn == 5'd31) ? 8 : 9) : 0;
            check(nrd == exp_nrd, {name, " R1 R8 read count"}, nrd, exp_nrd);
            @(negedge clk);
            check(!fault_valid && !req_valid && cmd_ready, {name, " R11 idle after fault"},
                  {fault_valid, req_valid, cmd_ready}, 3'b001);
        end else begin
            exp_nrd = (rn == 5'd31) ? 8 : 9;
            check(nrd == exp_nrd, {name, " R3 read count"}, nrd, exp_nrd);
            for (int i = 0; i < 8; i++) begin
                if (i < nrd) check(rd_log[i] == rt + 5'(i), {name, " R3 read order"}, rd_log[i], rt + 5'(i));
            end
            if (rn != 5'd31 && nrd == 9) check(rd_log[8] == rn, {name, " R3 base read"}, rd_log[8], rn);
            for (int i = 0; i < 8; i++) begin
                exp_data[64*i +: 64] = be ? rev8(regs[rt + 5'(i)]) : regs[rt + 5'(i)];
            end
            exp_addr = (rn == 5'd31) ? sp : regs[rn];
            check(req_data == exp_data, {name, be ? " R5 payload" : " R4 payload"}, req_data, exp_data);
            check(req_addr == exp_addr, {name, " R6 address"}, req_addr, exp_addr);
            check(req_tagchk == (rn != 5'd31), {name, " R7 tag flag"}, req_tagchk, rn != 5'd31);
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                check(req_valid && req_data == exp_data && req_addr == exp_addr,
                      {name, " R10 hold while stalled"}, {req_valid, req_addr}, {1'b1, exp_addr});
            end
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            check(!req_valid && cmd_ready, {name, " R10 R11 drop after take"},
                  {req_valid, cmd_ready}, 2'b01);
        end
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            for (int b = 0; b < 8; b++) regs[i][8*b +: 8] = 8'(i * 8 + b);
        end
        regs[5] = 64'h0000_1234_5678_9AC0;
        regs[3] = 64'h8000_0000_0000_0040;
        regs[7] = 64'h0000_0000_0001_0020;
        rst = 1'b1; cmd_valid = 1'b0; cmd_rt = '0; cmd_rn = '0; feat_en = 1'b0;
        big_endian = 1'b0; sp_value = '0; req_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(cmd_ready && !req_valid && !fault_valid && !rf_rd_en, "reset state R11",
              {cmd_ready, req_valid, fault_valid, rf_rd_en}, 4'b1000);
        run_case("le_base",   5'd0,  5'd5,  1'b1, 1'b0, 64'h0,                 2'd0, 9, 3);
        run_case("be_base",   5'd10, 5'd3,  1'b1, 1'b1, 64'h0,                 2'd0, 9, 0);
        run_case("sp_path",   5'd20, 5'd31, 1'b1, 1'b0, 64'h0000_7FFF_0000_1000, 2'd0, 8, 2);
        run_case("sp_be",     5'd16, 5'd31, 1'b1, 1'b1, 64'h0000_0000_0000_0FC0, 2'd0, 8, 0);
        run_case("feat_off",  5'd0,  5'd31, 1'b0, 1'b0, 64'h0000_0000_0000_0008, 2'd1, 0, 0);
        run_case("rt_hi",     5'd24, 5'd5,  1'b1, 1'b0, 64'h0,                 2'd1, 0, 0);
        run_case("rt_odd",    5'd3,  5'd31, 1'b1, 1'b0, 64'h0000_0000_0000_0004, 2'd1, 0, 0);
        run_case("sp_mis16",  5'd2,  5'd31, 1'b1, 1'b0, 64'h0000_0000_0000_1008, 2'd2, 0, 0);
        run_case("sp_mis64",  5'd2,  5'd31, 1'b1, 1'b0, 64'h0000_0000_0000_1030, 2'd3, 8, 0);
        run_case("base_mis",  5'd12, 5'd7,  1'b1, 1'b0, 64'h0,                 2'd3, 9, 0);
        run_case("le_again",  5'd22, 5'd5,  1'b1, 1'b0, 64'h0,                 2'd0, 9, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule